// File: doc/BRIEF.md
# Flow-Through Burst SRAM Front End

This block models the synchronous front end of a flow-through burst SRAM, with a small 18-bit memory array behind it. On each rising clock edge it samples the address, three chip enables of mixed polarity, and two burst-start strobes. It also samples an advance strobe, the write controls and the write data. From these it classifies the cycle as deselect, burst begin, burst continue or burst suspend. Writes land in the array on the same edge, split into two 9-bit lanes. Reads come out combinationally during the following cycle, and there is no output register.

The two start strobes behave differently. The host strobe outranks the memory-controller strobe, but it is honoured only while the primary low-true enable is asserted, and it always begins a read. The memory-controller strobe begins a read or a write, depending on the decoded write controls. Once a burst is running, the advance strobe steps a four-beat counter through either a linear or an interleaved order, or holds the current address. Write data is a plain parallel input and read data is a plain output with a drive qualifier, so there is no stream handshake and no back-pressure at the block's edge.

Top module: `burst_sram_fe`

## Requirements
- R1: The device counts as selected only when `sel_a_n`=0, `sel_hi`=1 and `sel_b_n`=0. A start (memory-controller strobe low, or host strobe low with `sel_a_n`=0) sampled while not selected is a deselect cycle. It ends any burst, and `rdata_drv` is 0 in the following cycle.
- R2: `start_host_n`=0 with `sel_a_n`=0 and the device selected begins a read burst at `addr`. It writes nothing, whatever the write pins are.
- R3: `start_mc_n`=0 with the host strobe not honoured and the device selected begins a burst at `addr`. It is a write when the decoded write is active, otherwise a read.
- R4: While `sel_a_n`=1 the host strobe has no effect, and the cycle is decoded as if it were high.
- R5: With no start, `adv_n`=0 continues the burst at the next beat and `adv_n`=1 suspends it at the current beat. Either kind may read or write. Both are ignored (no write, bus undriven) when no burst is active.
- R6: The decoded write is active when `all_wr_n`=0, or when `byte_wr_n`=0 and any bit of `lane_n` is 0. `all_wr_n`=0 writes both lanes. Otherwise, with `byte_wr_n`=0, `lane_n[0]`=0 writes bits 8:0 and `lane_n[1]`=0 writes bits 17:9. `lane_n` has no effect while `byte_wr_n`=1.
- R7: For start address low bits s and beat i (0..3, a two-bit count that wraps after four beats), the low two address bits are (s+i) mod 4 when `seq_linear`=1 and s XOR i when `seq_linear`=0. The upper address bits stay at the start value.
- R8: A read registered at an edge presents the array word at its address during the next cycle. A write commits at its own edge, so a read of that address in the next cycle returns the new word.
- R9: `rdata_drv` is 1 only in the cycle after a read cycle and only while `oe_n`=0. `oe_n` acts without waiting for a clock edge. `rdata` is zero whenever `rdata_drv` is 0.
- R10: During and after reset the device is deselected, no burst is active and `rdata_drv` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_linear | input | 1 | 1 selects linear burst order, 0 selects interleaved |
| addr | input | AW | External word address |
| sel_a_n | input | 1 | Primary chip enable, active low; gates the host strobe |
| sel_hi | input | 1 | Chip enable, active high |
| sel_b_n | input | 1 | Second chip enable, active low |
| start_host_n | input | 1 | Host burst-start strobe, active low, read-only |
| start_mc_n | input | 1 | Memory-controller burst-start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Write both lanes, active low |
| byte_wr_n | input | 1 | Enables per-lane writes, active low |
| lane_n | input | 2 | Per-lane write enables, active low |
| wdata | input | 18 | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | 18 | Read data, zero when not driven |
| rdata_drv | output | 1 | High when `rdata` would drive the bus |

## Verification
The properties assume every synchronous input is a defined level at each rising edge once reset is released. They also assume `oe_n` settles between edges, so its value sampled at an edge is the value the output logic saw during the preceding cycle. The bench changes every input two time units after a rising edge and samples outputs just before the next change, so all inputs are stable across each edge. Asynchronous `oe_n` behaviour is probed mid-cycle without a clock edge.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE  = 3'd0,
    CYC_DESEL = 3'd1,
    CYC_BEGIN = 3'd2,
    CYC_CONT  = 3'd3,
    CYC_SUSP  = 3'd4
  } cyc_e;
endpackage

// File: rtl/bsr_decode.sv
module bsr_decode
  import bsr_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             sel_a_n,
  input  logic             sel_hi,
  input  logic             sel_b_n,
  input  logic             start_host_n,
  input  logic             start_mc_n,
  input  logic             adv_n,
  input  logic             all_wr_n,
  input  logic             byte_wr_n,
  input  logic [LANES-1:0] lane_n,
  input  logic             burst_on,
  output cyc_e             kind,
  output logic             is_wr,
  output logic [LANES-1:0] lane_we
);
  logic selected;
  logic host_go;
  logic wr_req;
  logic [LANES-1:0] lane_sel;

  assign selected = !sel_a_n && sel_hi && !sel_b_n;
  assign host_go  = !start_host_n && !sel_a_n;
  assign wr_req   = !all_wr_n || (!byte_wr_n && (lane_n != {LANES{1'b1}}));

  always_comb begin
    if (!all_wr_n)       lane_sel = {LANES{1'b1}};
    else if (!byte_wr_n) lane_sel = ~lane_n;
    else                 lane_sel = '0;
  end

  always_comb begin
    kind  = CYC_IDLE;
    is_wr = 1'b0;
    if (host_go) begin
      kind  = selected ? CYC_BEGIN : CYC_DESEL;
      is_wr = 1'b0;
    end else if (!start_mc_n) begin
      kind  = selected ? CYC_BEGIN : CYC_DESEL;
      is_wr = selected && wr_req;
    end else if (burst_on) begin
      kind  = adv_n ? CYC_SUSP : CYC_CONT;
      is_wr = wr_req;
    end
  end

  assign lane_we = is_wr ? lane_sel : '0;
endmodule

// File: rtl/bsr_seq.sv
module bsr_seq
  import bsr_pkg::*;
#(
  parameter int AW     = 6,
  parameter int BEAT_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          seq_linear,
  input  cyc_e          kind,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] op_addr,
  output logic [AW-1:0] cur_addr,
  output logic          burst_on
);
  logic [AW-1:0]     base_q;
  logic [BEAT_W-1:0] cnt_q;
  logic              on_q;
  logic [BEAT_W-1:0] cnt_nx;

  function automatic logic [AW-1:0] beat_addr(
    input logic [AW-1:0] b, input logic [BEAT_W-1:0] c, input logic lin);
    logic [BEAT_W-1:0] lo;
    lo = lin ? (b[BEAT_W-1:0] + c) : (b[BEAT_W-1:0] ^ c);
    return {b[AW-1:BEAT_W], lo};
  endfunction

  assign cnt_nx   = cnt_q + 1'b1;
  assign cur_addr = beat_addr(base_q, cnt_q, seq_linear);
  assign burst_on = on_q;

  always_comb begin
    case (kind)
      CYC_BEGIN: op_addr = ext_addr;
      CYC_CONT:  op_addr = beat_addr(base_q, cnt_nx, seq_linear);
      default:   op_addr = cur_addr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      on_q   <= 1'b0;
    end else begin
      case (kind)
        CYC_BEGIN: begin
          base_q <= ext_addr;
          cnt_q  <= '0;
          on_q   <= 1'b1;
        end
        CYC_CONT:  cnt_q <= cnt_nx;
        CYC_DESEL: on_q  <= 1'b0;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/bsr_array.sv
module bsr_array #(
  parameter int AW     = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic [AW-1:0]           waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [AW-1:0]           raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
    end
    assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/burst_sram_fe.sv
module burst_sram_fe
  import bsr_pkg::*;
#(
  parameter int AW     = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seq_linear,
  input  logic [AW-1:0]    addr,
  input  logic             sel_a_n,
  input  logic             sel_hi,
  input  logic             sel_b_n,
  input  logic             start_host_n,
  input  logic             start_mc_n,
  input  logic             adv_n,
  input  logic             all_wr_n,
  input  logic             byte_wr_n,
  input  logic [LANES-1:0] lane_n,
  input  logic [DW-1:0]    wdata,
  input  logic             oe_n,
  output logic [DW-1:0]    rdata,
  output logic             rdata_drv
);
  cyc_e             kind;
  logic             is_wr;
  logic [LANES-1:0] lane_we;
  logic             burst_on;
  logic [AW-1:0]    op_addr;
  logic [AW-1:0]    cur_addr;
  logic [DW-1:0]    arr_q;
  logic             rd_q;
  logic             is_access;

  bsr_decode #(.LANES(LANES)) u_dec (
    .sel_a_n(sel_a_n), .sel_hi(sel_hi), .sel_b_n(sel_b_n),
    .start_host_n(start_host_n), .start_mc_n(start_mc_n), .adv_n(adv_n),
    .all_wr_n(all_wr_n), .byte_wr_n(byte_wr_n), .lane_n(lane_n),
    .burst_on(burst_on), .kind(kind), .is_wr(is_wr), .lane_we(lane_we)
  );

  bsr_seq #(.AW(AW), .BEAT_W(2)) u_seq (
    .clk(clk), .rst_n(rst_n), .seq_linear(seq_linear), .kind(kind),
    .ext_addr(addr), .op_addr(op_addr), .cur_addr(cur_addr),
    .burst_on(burst_on)
  );

  bsr_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk(clk), .we(lane_we), .waddr(op_addr), .wdata(wdata),
    .raddr(cur_addr), .rdata(arr_q)
  );

  assign is_access = (kind == CYC_BEGIN) || (kind == CYC_CONT) || (kind == CYC_SUSP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= is_access && !is_wr;
  end

  assign rdata_drv = rd_q && !oe_n;
  assign rdata     = rdata_drv ? arr_q : '0;
endmodule

// File: rtl/burst_sram_fe_chk.sv
module burst_sram_fe_chk #(
  parameter int AW = 6,
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel_a_n,
  input logic          sel_hi,
  input logic          sel_b_n,
  input logic          start_host_n,
  input logic          start_mc_n,
  input logic          adv_n,
  input logic          all_wr_n,
  input logic          byte_wr_n,
  input logic [1:0]    lane_n,
  input logic          oe_n,
  input logic [DW-1:0] rdata,
  input logic          rdata_drv
);
  logic sel_ok, host_ok, any_start, wr_dec;
  assign sel_ok    = !sel_a_n && sel_hi && !sel_b_n;
  assign host_ok   = !start_host_n && !sel_a_n;
  assign any_start = host_ok || !start_mc_n;
  assign wr_dec    = !all_wr_n || (!byte_wr_n && (lane_n != 2'b11));

  p_deselect_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (any_start && !sel_ok) |=> !rdata_drv);

  p_host_reads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ok && sel_ok) |=> (oe_n || rdata_drv));

  p_mc_write_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_ok && !start_mc_n && sel_ok && wr_dec) |=> !rdata_drv);

  p_suspend_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_drv && !any_start && adv_n && !wr_dec) |=> (oe_n || $stable(rdata)));

  p_oe_gates_r9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!rdata_drv && rdata == '0));
endmodule

bind burst_sram_fe burst_sram_fe_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_hi(sel_hi),
  .sel_b_n(sel_b_n), .start_host_n(start_host_n), .start_mc_n(start_mc_n),
  .adv_n(adv_n), .all_wr_n(all_wr_n), .byte_wr_n(byte_wr_n),
  .lane_n(lane_n), .oe_n(oe_n), .rdata(rdata), .rdata_drv(rdata_drv)
);

// File: tb/burst_sram_fe_test.sv
module burst_sram_fe_test;
  localparam int CLK_P = 10;
  localparam int AW = 6;
  localparam int DW = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seq_linear = 1'b1;
  logic [AW-1:0] addr = '0;
  logic sel_a_n = 1'b0, sel_hi = 1'b1, sel_b_n = 1'b0;
  logic start_host_n = 1'b1, start_mc_n = 1'b1, adv_n = 1'b1;
  logic all_wr_n = 1'b1, byte_wr_n = 1'b1;
  logic [1:0] lane_n = 2'b11;
  logic [DW-1:0] wdata = '0;
  logic oe_n = 1'b0;
  logic [DW-1:0] rdata;
  logic rdata_drv;

  int total = 0, fails = 0;
  bit done = 0;
  logic [DW-1:0] rm [64];

  always #(CLK_P/2) clk = ~clk;

  burst_sram_fe uut (.*);

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    start_host_n = 1; start_mc_n = 1; adv_n = 1;
    all_wr_n = 1; byte_wr_n = 1; lane_n = 2'b11;
  endtask

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic host_read(int a);
    idle(); start_host_n = 0; addr = AW'(a); cyc(); idle();
  endtask

  function automatic int beat(int b, int i, bit lin);
    int lo;
    lo = lin ? ((b + i) & 3) : ((b ^ i) & 3);
    return (b & ~3) | lo;
  endfunction

  function automatic logic [DW-1:0] pat(int a);
    return DW'((a * 1237 + 91) & 18'h3ffff);
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #2;
    chk("R10 drv in reset", rdata_drv, 0);
    rst_n = 1;
    cyc();
    chk("R10 drv after reset", rdata_drv, 0);
    // R5: continue write with no active burst is ignored
    all_wr_n = 0; adv_n = 0; wdata = 18'h3ffff; cyc(); idle();
    chk("R5 no burst drv", rdata_drv, 0);

    // fill via memory-controller writes (R3, R6)
    for (int a = 0; a < 64; a++) begin
      idle(); start_mc_n = 0; all_wr_n = 0; addr = AW'(a); wdata = pat(a);
      cyc(); rm[a] = pat(a);
      chk("R3 write cycle drv", rdata_drv, 0);
    end
    idle();
    for (int a = 0; a < 64; a++) begin
      host_read(a);
      chk("R2 host read drv", rdata_drv, 1);
      chk("R8 host read data", rdata, rm[a]);
    end

    // burst orders (R7)
    for (int lin = 0; lin < 2; lin++) begin
      seq_linear = lin[0];
      for (int s = 0; s < 4; s++) begin
        host_read(8 + s);
        chk("R7 beat0", rdata, rm[8 + s]);
        for (int i = 1; i < 5; i++) begin
          adv_n = 0; cyc(); idle();
          chk("R7 burst beat", rdata, rm[beat(8 + s, i, lin[0])]);
        end
      end
    end

    // suspend (R5)
    seq_linear = 0;
    host_read(21);
    adv_n = 0; cyc(); idle();
    chk("R5 continue", rdata, rm[beat(21, 1, 0)]);
    adv_n = 1; cyc();
    chk("R5 suspend holds", rdata, rm[beat(21, 1, 0)]);
    adv_n = 0; cyc(); idle();
    chk("R5 continue after suspend", rdata, rm[beat(21, 2, 0)]);
    seq_linear = 1;

    // host strobe ignored when primary enable high (R4)
    host_read(30);
    sel_a_n = 1; start_host_n = 0; addr = 6'd40; adv_n = 1; cyc();
    chk("R4 host ignored suspend", rdata, rm[30]);
    adv_n = 0; cyc();
    chk("R4 host ignored continue", rdata, rm[31]);
    sel_a_n = 0; idle();

    // host start ignores write pins (R2), wait-cycle writes (R5, R8)
    idle(); start_host_n = 0; all_wr_n = 0; addr = 6'd33; wdata = ~rm[33];
    cyc(); idle();
    chk("R2 host start reads drv", rdata_drv, 1);
    chk("R2 host start no write", rdata, rm[33]);
    all_wr_n = 0; adv_n = 1; wdata = 18'h15a5a; cyc(); idle();
    rm[33] = 18'h15a5a;
    chk("R5 suspend write drv", rdata_drv, 0);
    all_wr_n = 0; adv_n = 0; wdata = 18'h0a5a5; cyc(); idle();
    rm[34] = 18'h0a5a5;
    host_read(33);
    chk("R8 suspend write landed", rdata, rm[33]);
    host_read(34);
    chk("R8 continue write landed", rdata, rm[34]);

    // lane writes (R6)
    for (int g = 0; g < 2; g++)
      for (int b = 0; b < 2; b++)
        for (int l = 0; l < 4; l++) begin
          logic [DW-1:0] d;
          bit wr;
          d = pat(100 + g * 8 + b * 4 + l) ^ 18'h2aaaa;
          idle(); start_mc_n = 0; addr = 6'd50; all_wr_n = g[0];
          byte_wr_n = b[0]; lane_n = l[1:0]; wdata = d;
          cyc(); idle();
          wr = (g == 0) || (b == 0 && l != 3);
          chk("R6 decoded write drv", rdata_drv, !wr);
          if (g == 0) rm[50] = d;
          else if (b == 0) begin
            if (!l[0]) rm[50][8:0]  = d[8:0];
            if (!l[1]) rm[50][17:9] = d[17:9];
          end
          host_read(50);
          chk("R6 lane result", rdata, rm[50]);
        end

    // enable decode (R1)
    for (int e = 0; e < 8; e++) begin
      sel_a_n = e[0]; sel_hi = e[1]; sel_b_n = e[2];
      idle(); start_mc_n = 0; addr = AW'(e + 1); cyc(); idle();
      chk("R1 select decode", rdata_drv, (e == 2) ? 1 : 0);
      if (e == 2) chk("R1 selected data", rdata, rm[e + 1]);
    end
    // burst ended: continue and suspend writes ignored (R1, R5)
    sel_a_n = 0; sel_hi = 0; sel_b_n = 0;
    idle(); all_wr_n = 0; adv_n = 0; wdata = 18'h00001; cyc();
    chk("R5 ended continue drv", rdata_drv, 0);
    adv_n = 1; cyc(); idle();
    sel_hi = 1;
    host_read(3);
    chk("R1 no write after deselect a", rdata, rm[3]);
    host_read(4);
    chk("R1 no write after deselect b", rdata, rm[4]);
    // host start while not selected
    sel_hi = 0; idle(); start_host_n = 0; addr = 6'd5; cyc(); idle();
    chk("R1 host deselect", rdata_drv, 0);
    sel_hi = 1;

    // async output enable (R9)
    oe_n = 1; host_read(12);
    chk("R9 oe high drv", rdata_drv, 0);
    chk("R9 oe high data", rdata, 0);
    #1 oe_n = 0; #1;
    chk("R9 oe low async drv", rdata_drv, 1);
    chk("R9 oe low async data", rdata, rm[12]);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule